// File: doc/BRIEF.md
# Event-Triggered Single-Channel DMA Engine

This block is one DMA channel. It copies bytes from a source region to a destination region with no processor involvement. Software sets a small bank of write-only configuration registers: two base addresses, three sizes, an event-select register and a channel-control register. The channel then watches a bank of interrupt-request lines. A rising edge on the selected line sets a pending flag that belongs to the channel and nothing else. Each pending request the channel accepts moves one cell of bytes over a byte-wide master port, one byte per clock.

The source and destination keep separate offset pointers. Each pointer wraps at its own size. A block ends once the number of bytes moved reaches the larger of the two sizes. The block may therefore span several requests, and a narrow destination may be written again and again. For example, a 2-byte source, a 1-byte destination and a 1-byte cell take two requests, and both bytes land on the same destination byte.

Base addresses written by software are reduced to physical form on the way in. A write to the abort register ends any activity at once.

Top module: `dma_chan_engine`

## Requirements
- R1: A write to the source-base register (address 2) or the destination-base register (address 3) stores the value ANDed with 0x1FFFFFFF. The bus read address is the source base plus the source offset. The bus write address is the destination base plus the destination offset.
- R2: The event-select register (address 1) holds the request number in bits 15:8 and start-enable in bit 4. A rising edge on `irq_in[number]` sets the pending flag only while start-enable is 1. Edges on other lines, or edges while start-enable is 0, leave the flag clear.
- R3: The cycle after the channel sees pending with enable set, it clears pending and starts a cell. It moves one byte per cycle (`m_rd_en` and `m_wr_en` high together, write data equal to read data). One request moves at most cell-size bytes (register 6).
- R4: After each byte, the source offset and the destination offset each advance by one. Each offset wraps to zero when it reaches its own size (register 4 for the source, register 5 for the destination).
- R5: The block completes once the number of bytes moved equals the larger of the two sizes, even if this happens part-way through a cell. On completion both offsets return to zero and `blk_done_o` pulses for one cycle.
- R6: The control register (address 0) holds channel enable in bit 7, auto-enable in bit 4 and priority in bits 1:0; `prio_o` shows the priority. At block completion the enable clears, unless auto-enable is 1.
- R7: A request that arrives while a cell is in progress stays pending. It is serviced directly after that cell ends.
- R8: Any write to address 7 stops the transfer in that same cycle, with no byte moved in that cycle. It also clears pending, returns both offsets to zero, clears the enable and pulses `aborted_o` for one cycle.
- R9: Sizes are 16-bit, so each can be up to 65,535. A size field of 0 behaves as 1.
- R10: After reset, all registers are zero, the channel is idle, and no bus strobe, pending flag or pulse output is active.
- R11: While the channel is disabled, a captured request stays pending and no byte moves. Setting enable later starts the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| irq_in | input | NIRQ | Interrupt-request line bank |
| m_rd_en | output | 1 | Byte read strobe |
| m_rd_addr | output | 32 | Byte read address |
| m_rd_data | input | 8 | Read data, valid in the same cycle |
| m_wr_en | output | 1 | Byte write strobe |
| m_wr_addr | output | 32 | Byte write address |
| m_wr_data | output | 8 | Byte write data |
| busy_o | output | 1 | Cell in progress |
| pending_o | output | 1 | Captured request waiting |
| chan_en_o | output | 1 | Channel enable state |
| prio_o | output | 2 | Programmed priority |
| blk_done_o | output | 1 | One-cycle block-complete pulse |
| aborted_o | output | 1 | One-cycle abort pulse |

## Verification
A stale source or destination offset shows on the next byte, as a wrong bus address, and as a wrong byte in destination memory once that cell ends. A wrong block counter shows as a `blk_done_o` pulse early, late or missing within one block's worth of requests. A dropped or doubled pending flag changes the number of write strobes within a few cycles of the request edge. The bench counts those strobes exactly, and it compares the whole destination window with a model built from the wrap rules after every request sequence.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int AW  = 32;
  localparam int SZW = 16;
  localparam int RNW = 8;

  localparam logic [AW-1:0] PHYS_MASK = 32'h1FFF_FFFF;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_EVT   = 3'd1;
  localparam logic [2:0] RA_SRC   = 3'd2;
  localparam logic [2:0] RA_DST   = 3'd3;
  localparam logic [2:0] RA_SSZ   = 3'd4;
  localparam logic [2:0] RA_DSZ   = 3'd5;
  localparam logic [2:0] RA_CSZ   = 3'd6;
  localparam logic [2:0] RA_ABORT = 3'd7;

  typedef enum logic {ST_IDLE, ST_XFER} xfer_st_t;

  typedef struct packed {
    logic           en;
    logic           auto_en;
    logic [1:0]     prio;
    logic [RNW-1:0] req_num;
    logic           start_en;
    logic [AW-1:0]  src_base;
    logic [AW-1:0]  dst_base;
    logic [SZW-1:0] ssz;
    logic [SZW-1:0] dsz;
    logic [SZW-1:0] csz;
  } chan_cfg_t;

  function automatic logic [AW-1:0] to_phys(input logic [AW-1:0] v);
    return v & PHYS_MASK;
  endfunction

  // a programmed size of zero counts as one byte
  function automatic logic [SZW-1:0] eff_size(input logic [SZW-1:0] s);
    return (s == '0) ? SZW'(1) : s;
  endfunction

  function automatic logic [SZW-1:0] blk_len(input logic [SZW-1:0] a,
                                             input logic [SZW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [SZW-1:0] wrap_next(input logic [SZW-1:0] p,
                                               input logic [SZW-1:0] lim);
    return (p + SZW'(1) >= lim) ? '0 : p + SZW'(1);
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [2:0]      addr,
  input  logic [AW-1:0]   wdata,
  input  logic            done_clr,
  output logic            abort_hit,
  output chan_cfg_t       cfg
);
  logic ctrl_wr;
  assign ctrl_wr   = we && (addr == RA_CTRL);
  assign abort_hit = we && (addr == RA_ABORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (we) begin
        case (addr)
          RA_CTRL: begin
            cfg.en      <= wdata[7];
            cfg.auto_en <= wdata[4];
            cfg.prio    <= wdata[1:0];
          end
          RA_EVT: begin
            cfg.req_num  <= wdata[15:8];
            cfg.start_en <= wdata[4];
          end
          RA_SRC:  cfg.src_base <= to_phys(wdata);
          RA_DST:  cfg.dst_base <= to_phys(wdata);
          RA_SSZ:  cfg.ssz <= wdata[SZW-1:0];
          RA_DSZ:  cfg.dsz <= wdata[SZW-1:0];
          RA_CSZ:  cfg.csz <= wdata[SZW-1:0];
          default: ;
        endcase
      end
      if (!ctrl_wr && (done_clr || abort_hit)) cfg.en <= 1'b0;
    end
  end

  // R6
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !ctrl_wr) |=> !cfg.en);

  // R8
  abort_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> !cfg.en);
endmodule

// File: rtl/dma_trig_capture.sv
module dma_trig_capture #(
  parameter int NIRQ = 32,
  parameter int RNW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_in,
  input  logic [RNW-1:0]  req_num,
  input  logic            start_en,
  input  logic            consume,
  input  logic            flush,
  output logic            pend
);
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  logic sel_now, sel_prev, set_ev;

  assign sel_now = ({1'b0, req_num} < (RNW+1)'(NIRQ)) ? irq_in[req_num[IW-1:0]] : 1'b0;
  assign set_ev  = start_en && sel_now && !sel_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_prev <= 1'b0;
      pend     <= 1'b0;
    end else begin
      sel_prev <= sel_now;
      pend     <= set_ev || (pend && !consume && !flush);
    end
  end

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> pend);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !consume && !flush) |=> pend);

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !set_ev) |=> !pend);
endmodule

// File: rtl/dma_wrap_ptr.sv
module dma_wrap_ptr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic [W-1:0] lim,
  output logic [W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (clr) ptr <= '0;
    else if (inc) ptr <= (ptr + W'(1) >= lim) ? '0 : ptr + W'(1);
  end

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && (ptr + W'(1) == lim)) |=> (ptr == '0));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && (ptr + W'(1) < lim)) |=> (ptr == $past(ptr) + W'(1)));
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int NIRQ = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  input  logic [NIRQ-1:0] irq_in,
  output logic            m_rd_en,
  output logic [31:0]     m_rd_addr,
  input  logic [7:0]      m_rd_data,
  output logic            m_wr_en,
  output logic [31:0]     m_wr_addr,
  output logic [7:0]      m_wr_data,
  output logic            busy_o,
  output logic            pending_o,
  output logic            chan_en_o,
  output logic [1:0]      prio_o,
  output logic            blk_done_o,
  output logic            aborted_o
);
  chan_cfg_t      cfg;
  xfer_st_t       st;
  logic           abort_hit, pend;
  logic           start_cell, move_byte, last_blk, last_cell, done_clr;
  logic [SZW-1:0] slen, dlen, clen, blen;
  logic [SZW-1:0] blk_cnt, cel_cnt, sptr, dptr;
  logic           blk_done_q, aborted_q;

  assign slen = eff_size(cfg.ssz);
  assign dlen = eff_size(cfg.dsz);
  assign clen = eff_size(cfg.csz);
  assign blen = blk_len(slen, dlen);

  assign start_cell = (st == ST_IDLE) && cfg.en && pend && !abort_hit;
  assign move_byte  = (st == ST_XFER) && !abort_hit;
  assign last_blk   = move_byte && (blk_cnt + SZW'(1) >= blen);
  assign last_cell  = move_byte && (cel_cnt + SZW'(1) >= clen);
  assign done_clr   = last_blk && !cfg.auto_en;

  dma_chan_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .done_clr(done_clr), .abort_hit(abort_hit), .cfg(cfg)
  );

  dma_trig_capture #(.NIRQ(NIRQ), .RNW(RNW)) u_trig (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .req_num(cfg.req_num),
    .start_en(cfg.start_en), .consume(start_cell), .flush(abort_hit), .pend(pend)
  );

  dma_wrap_ptr #(.W(SZW)) u_sptr (
    .clk(clk), .rst_n(rst_n), .inc(move_byte), .clr(last_blk || abort_hit),
    .lim(slen), .ptr(sptr)
  );

  dma_wrap_ptr #(.W(SZW)) u_dptr (
    .clk(clk), .rst_n(rst_n), .inc(move_byte), .clr(last_blk || abort_hit),
    .lim(dlen), .ptr(dptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      blk_cnt    <= '0;
      cel_cnt    <= '0;
      blk_done_q <= 1'b0;
      aborted_q  <= 1'b0;
    end else begin
      blk_done_q <= last_blk;
      aborted_q  <= abort_hit;
      if (abort_hit) begin
        st      <= ST_IDLE;
        blk_cnt <= '0;
        cel_cnt <= '0;
      end else if (start_cell) begin
        st      <= ST_XFER;
        cel_cnt <= '0;
      end else if (move_byte) begin
        blk_cnt <= last_blk ? '0 : blk_cnt + SZW'(1);
        cel_cnt <= cel_cnt + SZW'(1);
        if (last_blk || last_cell) st <= ST_IDLE;
      end
    end
  end

  assign m_rd_en    = move_byte;
  assign m_wr_en    = move_byte;
  assign m_rd_addr  = cfg.src_base + {{(AW-SZW){1'b0}}, sptr};
  assign m_wr_addr  = cfg.dst_base + {{(AW-SZW){1'b0}}, dptr};
  assign m_wr_data  = m_rd_data;
  assign busy_o     = (st == ST_XFER);
  assign pending_o  = pend;
  assign chan_en_o  = cfg.en;
  assign prio_o     = cfg.prio;
  assign blk_done_o = blk_done_q;
  assign aborted_o  = aborted_q;

  // R3
  cell_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cel_cnt < clen));

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_cell |=> (busy_o && !pending_o) || !pending_o || busy_o);

  // R5
  blk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_blk |=> (blk_done_o && !busy_o && sptr == '0 && dptr == '0));

  // R8
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> (!busy_o && aborted_o && sptr == '0 && dptr == '0));

  // R10
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_wr_en |-> (m_rd_en && busy_o));
endmodule

// File: tb/sim_dma_chan_engine.sv
`timescale 1ns/1ps
module sim_dma_chan_engine;
  localparam int NIRQ = 32;
  localparam int TRIG = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NIRQ-1:0] irq_in = '0;
  logic m_rd_en, m_wr_en, busy_o, pending_o, chan_en_o, blk_done_o, aborted_o;
  logic [31:0] m_rd_addr, m_wr_addr;
  logic [7:0] m_rd_data, m_wr_data;
  logic [1:0] prio_o;

  logic [7:0] mem [0:1023];
  logic [7:0] exp_dst [0:15];
  int nchk = 0, nerr = 0;
  int wr_cnt = 0, done_cnt = 0, abort_cnt = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0;

  always #4 clk = ~clk;

  dma_chan_engine #(.NIRQ(NIRQ)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .irq_in(irq_in), .m_rd_en(m_rd_en),
    .m_rd_addr(m_rd_addr), .m_rd_data(m_rd_data), .m_wr_en(m_wr_en),
    .m_wr_addr(m_wr_addr), .m_wr_data(m_wr_data), .busy_o(busy_o),
    .pending_o(pending_o), .chan_en_o(chan_en_o), .prio_o(prio_o),
    .blk_done_o(blk_done_o), .aborted_o(aborted_o)
  );

  assign m_rd_data = mem[m_rd_addr[9:0]];

  always @(negedge clk) begin
    if (m_wr_en) begin
      mem[m_wr_addr[9:0]] = m_wr_data;
      wr_cnt = wr_cnt + 1;
      last_wr_addr = m_wr_addr;
    end
    if (m_rd_en) last_rd_addr = m_rd_addr;
    if (blk_done_o) done_cnt = done_cnt + 1;
    if (aborted_o) abort_cnt = abort_cnt + 1;
  end

  // {src size, dst size, cell size, request count}
  localparam logic [55:0] VEC [0:5] = '{
    {16'd2, 16'd1, 16'd1, 8'd2},
    {16'd4, 16'd4, 16'd2, 8'd2},
    {16'd3, 16'd5, 16'd2, 8'd3},
    {16'd6, 16'd2, 16'd4, 8'd1},
    {16'd1, 16'd3, 16'd1, 8'd4},
    {16'd0, 16'd0, 16'd0, 8'd2}
  };

  function automatic logic [7:0] srcpat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk = nchk + 1;
    if (!ok) begin
      nerr = nerr + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire_line(input int n);
    @(negedge clk); irq_in[n] = 1'b1;
    @(negedge clk); irq_in[n] = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while ((busy_o || pending_o) && t < 300) begin
      @(negedge clk);
      t = t + 1;
    end
  endtask

  task automatic clear_dst();
    for (int i = 0; i < 16; i++) begin
      mem[512 + i] = 8'h00;
      exp_dst[i] = 8'h00;
    end
  endtask

  task automatic setup(input int ss, input int ds, input int cs, input bit au,
                       input logic [1:0] pr);
    cfg_wr(3'd7, 32'h0);
    cfg_wr(3'd2, 32'hA000_0100);
    cfg_wr(3'd3, 32'h8000_0200);
    cfg_wr(3'd4, 32'(ss));
    cfg_wr(3'd5, 32'(ds));
    cfg_wr(3'd6, 32'(cs));
    cfg_wr(3'd1, {16'h0, 8'(TRIG), 8'h10});
    cfg_wr(3'd0, {24'h0, 1'b1, 2'b00, au, 2'b00, pr});
  endtask

  // model built from the wrap and block-length rules
  task automatic model(input int ss, input int ds, input int cs, input int nt,
                       output int dn);
    int s, d, c, bl, sp, dp, bc;
    s = (ss == 0) ? 1 : ss;
    d = (ds == 0) ? 1 : ds;
    c = (cs == 0) ? 1 : cs;
    bl = (s > d) ? s : d;
    sp = 0; dp = 0; bc = 0; dn = 0;
    for (int t = 0; t < nt; t++) begin
      for (int k = 0; k < c; k++) begin
        exp_dst[dp] = srcpat(sp);
        sp = (sp + 1 >= s) ? 0 : sp + 1;
        dp = (dp + 1 >= d) ? 0 : dp + 1;
        bc = bc + 1;
        if (bc == bl) begin
          dn = dn + 1; bc = 0; sp = 0; dp = 0;
          break;
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk = nchk + 1;
    nerr = nerr + 1;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int w0, d0, a0, dn, mism, bad_i;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    for (int i = 0; i < 64; i++) mem[256 + i] = srcpat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(!busy_o && !pending_o && !chan_en_o, "R10 idle after reset",
        {busy_o, pending_o, chan_en_o}, 0);
    chk(!m_wr_en && !m_rd_en && !blk_done_o && !aborted_o && prio_o == 0,
        "R10 strobes quiet", {m_wr_en, m_rd_en, blk_done_o, aborted_o, prio_o}, 0);

    // table of size/cell patterns: R3 R4 R5 R9
    for (int v = 0; v < 6; v++) begin
      int ss, ds, cs, nt;
      ss = int'(VEC[v][55:40]); ds = int'(VEC[v][39:24]);
      cs = int'(VEC[v][23:8]);  nt = int'(VEC[v][7:0]);
      setup(ss, ds, cs, 1'b1, 2'd0);
      clear_dst();
      model(ss, ds, cs, nt, dn);
      d0 = done_cnt;
      for (int t = 0; t < nt; t++) begin
        fire_line(TRIG);
        wait_idle();
      end
      repeat (2) @(negedge clk);
      mism = 0; bad_i = 0;
      for (int i = 0; i < 16; i++)
        if (mem[512 + i] !== exp_dst[i]) begin
          if (mism == 0) bad_i = i;
          mism = mism + 1;
        end
      chk(mism == 0, $sformatf("R3 R4 dst bytes vector %0d byte %0d", v, bad_i),
          mem[512 + bad_i], exp_dst[bad_i]);
      chk(done_cnt - d0 == dn, $sformatf("R5 R9 block count vector %0d", v),
          done_cnt - d0, dn);
    end
    // R6 auto-enable keeps the channel on
    chk(chan_en_o, "R6 auto-enable holds enable", chan_en_o, 1);

    // R1 physical addresses on the bus
    setup(1, 1, 1, 1'b1, 2'd2);
    fire_line(TRIG); wait_idle();
    chk(last_rd_addr == 32'h100, "R1 read address masked", last_rd_addr, 32'h100);
    chk(last_wr_addr == 32'h200, "R1 write address masked", last_wr_addr, 32'h200);
    chk(prio_o == 2'd2, "R6 priority output", prio_o, 2);

    // R2 start-enable off and wrong line
    setup(16, 16, 2, 1'b1, 2'd0);
    cfg_wr(3'd1, {16'h0, 8'(TRIG), 8'h00});
    w0 = wr_cnt;
    fire_line(TRIG); repeat (4) @(negedge clk);
    chk(!pending_o && wr_cnt == w0, "R2 start-enable off ignored", wr_cnt - w0, 0);
    cfg_wr(3'd1, {16'h0, 8'(TRIG), 8'h10});
    fire_line(5); repeat (4) @(negedge clk);
    chk(!pending_o && wr_cnt == w0, "R2 other line ignored", wr_cnt - w0, 0);

    // R11 disabled channel keeps the request
    cfg_wr(3'd0, 32'h0);
    fire_line(TRIG); repeat (4) @(negedge clk);
    chk(pending_o && wr_cnt == w0, "R11 pending held while disabled",
        {pending_o, 8'(wr_cnt - w0)}, 32'h100);
    cfg_wr(3'd0, 32'h90);
    wait_idle(); @(negedge clk);
    chk(wr_cnt - w0 == 2 && !pending_o, "R11 serviced after enable", wr_cnt - w0, 2);

    // R7 request during a cell
    setup(16, 16, 4, 1'b1, 2'd0);
    w0 = wr_cnt;
    fire_line(TRIG);
    fire_line(TRIG);
    chk(pending_o && busy_o, "R7 second request pending while busy",
        {pending_o, busy_o}, 2'b11);
    wait_idle(); @(negedge clk);
    chk(wr_cnt - w0 == 8, "R7 both cells moved", wr_cnt - w0, 8);

    // R6 enable clears at block end without auto-enable
    setup(2, 2, 2, 1'b0, 2'd0);
    d0 = done_cnt;
    fire_line(TRIG); wait_idle(); @(negedge clk);
    chk(done_cnt - d0 == 1 && !chan_en_o, "R6 enable cleared",
        {chan_en_o, 8'(done_cnt - d0)}, 1);

    // R8 abort in the middle of a cell
    setup(16, 16, 8, 1'b1, 2'd0);
    clear_dst();
    w0 = wr_cnt; a0 = abort_cnt;
    fire_line(TRIG);
    @(negedge clk); @(negedge clk);
    cfg_wr(3'd7, 32'h0);
    @(negedge clk);
    chk(!busy_o && !chan_en_o && abort_cnt - a0 == 1, "R8 abort stops channel",
        {busy_o, chan_en_o, 8'(abort_cnt - a0)}, 1);
    chk(wr_cnt - w0 > 0 && wr_cnt - w0 < 8, "R8 cell cut short", wr_cnt - w0, 4);
    clear_dst();
    cfg_wr(3'd0, 32'h90);
    fire_line(TRIG); wait_idle(); @(negedge clk);
    chk(mem[512] == srcpat(0) && mem[519] == srcpat(7), "R8 offsets restart at zero",
        mem[512], srcpat(0));

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule